// File: doc/BRIEF.md
# Masked CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is accepted. It compares the frame identifier, together with its RTR, IDE and SRR control bits, against programmable acceptance codes. Each code bit has a mask bit, and a set mask bit makes that position don't care. The same eight code bytes and eight mask bytes can be used as two wide filters, four medium filters or eight narrow filters. The bank can also be closed so that it accepts nothing.

The frame fields are packed into a 32-bit compare image. Every filter in the selected mode compares its code against its slice of that image, and this compare is combinational. On the frame-complete strobe the block latches two results: an accept flag and a 3-bit index naming the lowest-numbered filter that matched. Software programs the codes, the masks and the mode through a byte-wide register port, and it can read the latched hit index back through the same port.

Top module: `can_id_filter`

## Requirements
- R1: Register port. Addresses 0..7 hold code bytes 0..7 and addresses 8..15 hold mask bytes 0..7. Address 16 is control: bits [1:0] are the mode, and bits [6:4] read back the latched hit index and ignore writes. All registers read back combinationally on rd_data_o, and all reset to zero.
- R2: A mask bit of 1 makes the matching code bit don't care. A mask bit of 0 requires the image bit to equal the code bit.
- R3: Extended image (ide_i=1), MSB first: {id[28:21], id[20:18], srr, ide, id[17:15], id[14:0], rtr}. Standard image (ide_i=0): {id[10:3], id[2:0], rtr, ide, 3'b000, 16'h0000}. Code byte 0 lines up with image bits [31:24], and the remaining bytes follow downward in order.
- R4: Mode 0 (wide) has filter k (k=0,1), which compares bytes 4k..4k+3 against the whole image. For a standard frame, the lower 16 image bits are excluded from the compare.
- R5: Mode 1 (medium) has filter j (j=0..3), which compares bytes 2j and 2j+1 against image bits [31:16].
- R6: Mode 2 (narrow) has filter j (j=0..7), which compares byte j against image bits [31:24].
- R7: Mode 3 (closed) never accepts a frame.
- R8: When several filters match, the hit index names the lowest-numbered one.
- R9: accept_o and hit_o update only on the clock edge where frame_done_i is high. accept_o takes the match result. On a rejected frame, hit_o keeps its previous value.
- R10: While reset is asserted, accept_o is 0 and hit_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for writes and reads |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| id_i | input | 29 | Frame identifier (standard ID in bits [10:0]) |
| ide_i | input | 1 | Identifier extension bit |
| rtr_i | input | 1 | Remote request bit |
| srr_i | input | 1 | Substitute remote request bit |
| frame_done_i | input | 1 | Frame complete, latch the filter result |
| accept_o | output | 1 | Latched accept |
| hit_o | output | 3 | Latched index of the matching filter |

## Verification
The assertions check the following on every cycle:
- the results stay stable between frame strobes;
- a rejected frame leaves the index untouched;
- a match always sets accept;
- closed mode never accepts;
- in wide and medium mode the index stays inside the active filter range.

Only the bench scenarios can show that the image packing, the byte-to-filter mapping, the handling of the standard-frame tail in wide mode and the lowest-index priority are right. To do that they program codes and masks whose expected outcome was worked out by hand.

// File: rtl/can_id_filter_pkg.sv
package can_id_filter_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE   = 2'd0,
    MODE_MED    = 2'd1,
    MODE_NARROW = 2'd2,
    MODE_CLOSED = 2'd3
  } filt_mode_e;

  localparam int unsigned IMG_W = 32;

  function automatic logic [IMG_W-1:0] pack_image(input logic [28:0] id,
                                                  input logic ide,
                                                  input logic rtr,
                                                  input logic srr);
    logic [IMG_W-1:0] img;
    if (ide) img = {id[28:21], id[20:18], srr, ide, id[17:15], id[14:0], rtr};
    else     img = {id[10:3], id[2:0], rtr, ide, 3'b000, 16'h0000};
    return img;
  endfunction

endpackage

// File: rtl/can_id_filter_regs.sv
module can_id_filter_regs #(
  parameter int unsigned N_BYTES = 8,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned HIT_W   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic [HIT_W-1:0]       hit_i,
  output logic [7:0]             rd_data_o,
  output logic [N_BYTES*8-1:0]   code_o,
  output logic [N_BYTES*8-1:0]   mask_o,
  output logic [1:0]             mode_o
);
  localparam int unsigned CTRL_ADDR = 2 * N_BYTES;

  logic [7:0] code_q [N_BYTES];
  logic [7:0] mask_q [N_BYTES];
  logic [1:0] mode_q;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[b] <= '0;
        mask_q[b] <= '0;
      end else if (wr_en_i) begin
        if (addr_i == ADDR_W'(b))           code_q[b] <= wr_data_i;
        if (addr_i == ADDR_W'(b + N_BYTES)) mask_q[b] <= wr_data_i;
      end
    end
    // byte 0 sits at the top of the flattened vector
    assign code_o[(N_BYTES-1-b)*8 +: 8] = code_q[b];
    assign mask_o[(N_BYTES-1-b)*8 +: 8] = mask_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          mode_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(CTRL_ADDR))     mode_q <= wr_data_i[1:0];
  end

  assign mode_o = mode_q;

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (addr_i == ADDR_W'(i))           rd_data_o = code_q[i];
      if (addr_i == ADDR_W'(i + N_BYTES)) rd_data_o = mask_q[i];
    end
    if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rd_data_o[1:0]         = mode_q;
      rd_data_o[4 +: HIT_W]  = hit_i;
    end
  end

endmodule

// File: rtl/can_id_filter_match.sv
module can_id_filter_match
  import can_id_filter_pkg::*;
#(
  parameter int unsigned N_BYTES = 8
) (
  input  logic [IMG_W-1:0]       img_i,
  input  logic                   ide_i,
  input  logic [N_BYTES*8-1:0]   code_i,
  input  logic [N_BYTES*8-1:0]   mask_i,
  input  logic [1:0]             mode_i,
  output logic [N_BYTES-1:0]     hits_o
);
  localparam int unsigned N_MED  = N_BYTES / 2;
  localparam int unsigned N_WIDE = N_BYTES / 4;

  logic [N_BYTES-1:0] nar_hit;
  logic [N_MED-1:0]   med_hit;
  logic [N_WIDE-1:0]  wide_hit;
  logic [IMG_W-1:0]   wide_care;

  // standard frames carry nothing in the low half
  assign wide_care = {16'hFFFF, {16{ide_i}}};

  for (genvar j = 0; j < N_BYTES; j++) begin : g_nar
    assign nar_hit[j] = ((img_i[31:24] ^ code_i[(N_BYTES-1-j)*8 +: 8])
                         & ~mask_i[(N_BYTES-1-j)*8 +: 8]) == '0;
  end

  for (genvar j = 0; j < N_MED; j++) begin : g_med
    assign med_hit[j] = ((img_i[31:16] ^ code_i[(N_MED-1-j)*16 +: 16])
                         & ~mask_i[(N_MED-1-j)*16 +: 16]) == '0;
  end

  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    assign wide_hit[j] = ((img_i ^ code_i[(N_WIDE-1-j)*32 +: 32])
                          & ~mask_i[(N_WIDE-1-j)*32 +: 32] & wide_care) == '0;
  end

  always_comb begin
    hits_o = '0;
    unique case (filt_mode_e'(mode_i))
      MODE_WIDE:   hits_o[N_WIDE-1:0] = wide_hit;
      MODE_MED:    hits_o[N_MED-1:0]  = med_hit;
      MODE_NARROW: hits_o             = nar_hit;
      default:     hits_o             = '0;
    endcase
  end

endmodule

// File: rtl/can_id_filter_prio.sv
module can_id_filter_prio #(
  parameter int unsigned N     = 8,
  parameter int unsigned HIT_W = 3
) (
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [HIT_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = HIT_W'(i);
    end
  end

  assign any_o = |hits_i;

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_id_filter_pkg::*;
#(
  parameter int unsigned N_BYTES = 8,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned ID_W    = 29
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [7:0]                    wr_data_i,
  output logic [7:0]                    rd_data_o,
  input  logic [ID_W-1:0]               id_i,
  input  logic                          ide_i,
  input  logic                          rtr_i,
  input  logic                          srr_i,
  input  logic                          frame_done_i,
  output logic                          accept_o,
  output logic [$clog2(N_BYTES)-1:0]    hit_o
);
  localparam int unsigned HIT_W = $clog2(N_BYTES);

  logic [N_BYTES*8-1:0] code;
  logic [N_BYTES*8-1:0] mask;
  logic [1:0]           mode;
  logic [IMG_W-1:0]     img;
  logic [N_BYTES-1:0]   hits;
  logic                 match_any;
  logic [HIT_W-1:0]     match_idx;
  logic                 accept_q;
  logic [HIT_W-1:0]     hit_q;

  can_id_filter_regs #(
    .N_BYTES (N_BYTES),
    .ADDR_W  (ADDR_W),
    .HIT_W   (HIT_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .hit_i     (hit_q),
    .rd_data_o (rd_data_o),
    .code_o    (code),
    .mask_o    (mask),
    .mode_o    (mode)
  );

  assign img = pack_image(id_i, ide_i, rtr_i, srr_i);

  can_id_filter_match #(
    .N_BYTES (N_BYTES)
  ) i_match (
    .img_i  (img),
    .ide_i  (ide_i),
    .code_i (code),
    .mask_i (mask),
    .mode_i (mode),
    .hits_o (hits)
  );

  can_id_filter_prio #(
    .N     (N_BYTES),
    .HIT_W (HIT_W)
  ) i_prio (
    .hits_i (hits),
    .any_o  (match_any),
    .idx_o  (match_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      hit_q    <= '0;
    end else if (frame_done_i) begin
      accept_q <= match_any;
      if (match_any) hit_q <= match_idx;
    end
  end

  assign accept_o = accept_q;
  assign hit_o    = hit_q;

endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int unsigned HIT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_done_i,
  input logic [1:0]       mode_i,
  input logic             any_i,
  input logic             accept_i,
  input logic [HIT_W-1:0] hit_i
);

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (!accept_i && hit_i == '0);
  end

  // R7
  closed_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && mode_i == 2'd3) |=> !accept_i);

  // R9
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> ($stable(accept_i) && $stable(hit_i)));

  // R9
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !any_i) |=> (!accept_i && $stable(hit_i)));

  // R9
  match_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && any_i) |=> accept_i);

  // R4
  wide_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && any_i && mode_i == 2'd0) |=> (hit_i[HIT_W-1:1] == '0));

  // R5
  med_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && any_i && mode_i == 2'd1) |=> (hit_i[HIT_W-1] == 1'b0));

endmodule

bind can_id_filter can_id_filter_chk #(.HIT_W(HIT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_done_i (frame_done_i),
  .mode_i       (mode),
  .any_i        (match_any),
  .accept_i     (accept_o),
  .hit_i        (hit_o)
);

// File: tb/test_can_id_filter.sv
`timescale 1ns/1ps
module test_can_id_filter;

  typedef struct packed {
    logic [63:0] code;
    logic [63:0] mask;
    logic [1:0]  mode;
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic        srr;
    logic        acc;
    logic [2:0]  hit;
  } vec_t;

  localparam int NV = 13;
  // frames: F1 ext all-ones srr=1 -> FFFFFFFE; F2 std 7FF -> FFE00000;
  //         F3 std 0 rtr=1 -> 00100000; F4 ext 0 srr/rtr=1 -> 00180001
  localparam vec_t VEC [NV] = '{
    '{64'h00000000_FFFFFFFE, 64'h0, 2'd0, 29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1}, // R4 exact filter1
    '{64'hFFFFFFFE_FFFFFFFE, 64'h0, 2'd0, 29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0}, // R8 both
    '{64'hFFFFFFFE_FFFFFFFE, 64'h0, 2'd0, 29'h1FFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0}, // R3 rtr differs
    '{64'h0, 64'h00000000_FFFFFFFF, 2'd0, 29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1}, // R2 full mask
    '{64'hFFE01234_00000000, 64'h0, 2'd0, 29'h000007FF, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R4 std tail
    '{64'h1111_2222_0010_0010, 64'h0, 2'd1, 29'h0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2},     // R5 std
    '{64'h0019_0018_0000_0000, 64'h0, 2'd1, 29'h0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1},     // R5 ext
    '{64'h0, 64'h0018_0000_0000_0000, 2'd1, 29'h0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0},     // R2 partial
    '{64'h00112233_445566FF, 64'h0, 2'd2, 29'h000007FF, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7}, // R6 last
    '{64'h01020304_05000007, 64'h0, 2'd2, 29'h0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5},        // R8 narrow
    '{64'h0, 64'h0, 2'd2, 29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5},                 // R6 none
    '{64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 2'd3, 29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5}, // R7
    '{64'h0, 64'hFFFFFFFF_FFFFFFFF, 2'd0, 29'h0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0}         // R2 wide
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [28:0] id = '0;
  logic        ide = 1'b0, rtr = 1'b0, srr = 1'b0, frame_done = 1'b0;
  logic        accept;
  logic [2:0]  hit;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  can_id_filter i_can_id_filter (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .id_i(id), .ide_i(ide),
    .rtr_i(rtr), .srr_i(srr), .frame_done_i(frame_done),
    .accept_o(accept), .hit_o(hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #0.5; d = rd_data;
  endtask

  task automatic frame(input logic [28:0] i, input logic e, input logic r, input logic s);
    @(negedge clk); id = i; ide = e; rtr = r; srr = s; frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R10 accept in reset", 32'(accept), 0);
    check("R10 hit in reset", 32'(hit), 0);
    rst_n = 1'b1;
    rd(5'd16, d); check("R1 ctrl reset", 32'(d), 0);
    rd(5'd3, d);  check("R1 code reset", 32'(d), 0);

    wr(5'd3, 8'hA5);  rd(5'd3, d);  check("R1 code readback", 32'(d), 32'hA5);
    wr(5'd12, 8'h3C); rd(5'd12, d); check("R1 mask readback", 32'(d), 32'h3C);
    wr(5'd16, 8'h72); rd(5'd16, d); check("R1 hit bits ignore write", 32'(d), 32'h02);

    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < 8; b++) begin
        wr(5'(b), VEC[v].code[(7-b)*8 +: 8]);
        wr(5'(b + 8), VEC[v].mask[(7-b)*8 +: 8]);
      end
      wr(5'd16, {6'd0, VEC[v].mode});
      frame(VEC[v].id, VEC[v].ide, VEC[v].rtr, VEC[v].srr);
      check($sformatf("R9 accept vec %0d", v), 32'(accept), 32'(VEC[v].acc));
      check($sformatf("R8 hit vec %0d", v), 32'(hit), 32'(VEC[v].hit));
      rd(5'd16, d);
      check($sformatf("R1 hit readback vec %0d", v), 32'(d[6:4]), 32'(VEC[v].hit));
    end

    // R9: a changed identifier without a strobe leaves results alone
    @(negedge clk); id = 29'h1FFFFFFF; ide = 1'b1; rtr = 1'b0; srr = 1'b1;
    wr(5'd16, 8'h02);
    repeat (3) @(negedge clk);
    check("R9 hold accept", 32'(accept), 1);
    check("R9 hold hit", 32'(hit), 0);

    // R7: closed mode with a matching-everything mask
    wr(5'd16, 8'h03);
    frame(29'h0, 1'b0, 1'b0, 1'b0);
    check("R7 closed accept", 32'(accept), 0);

    // R10: reset clears latched result
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 accept after reset", 32'(accept), 0);
    check("R10 hit after reset", 32'(hit), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule